// File: doc/BRIEF.md
# Three-Wire Serial Master Controller

This block is a register-programmed master for a three-wire synchronous serial link (serial clock, serial data out, serial data in) with four active-low chip selects. A host programs it through a small word-addressed register bus. It loads a 16-bit transmit word, then writes one control word. That control word sets how many bits to send and how many to receive, which chip select to use, whether that select is asserted, and whether a transfer starts.

A transfer first shifts the transmit bits out, most significant first, starting from bit 15 of the transmit word. It then clocks in the requested number of receive bits. The received bits land right-aligned in the receive data register, and a ready flag is raised. The chip select stays asserted after a transfer until the host clears the assert bit, so a frame can span several words. A clock-enable setup register gates all shifting. A polarity setup register inverts the serial clock, which also swaps the launch and capture edges. Three further setup words are plain storage for per-select configuration fields.

Top module: `mw_master`

## Requirements
- R1: After reset the control word (index 1) reads 0, all chip selects are high, and sclk and sdo are low.
- R2: A control-word write with bit 12 set and bit 13 clear drives only chip select number bits [11:10] low. It does not start a transfer, and busy (bit 14) stays 0.
- R3: A control-word write with bit 12 clear drives all chip selects high.
- R4: A control-word write with bit 13 set while idle starts a transfer, and busy reads 1 from the next cycle. The transmit phase places bits [15:16-n] of the word written at index 0 on sdo, most significant first, where n is the transmit count in control bits [9:5].
- R5: After the transmit phase, the receive phase captures m bits from sdi, where m is the receive count in control bits [4:0]. They appear right-aligned at index 0 with the upper bits zero. The ready flag (bit 15) rises in the same cycle that busy falls.
- R6: Each serial bit lasts 4 system clock cycles, so busy stays high for exactly 4*(n+m) cycles.
- R7: With index 5 bit 0 clear, sclk idles low, sdo changes on its falling edge and sdi is captured on its rising edge. With that bit set, sclk idles high and both edges swap.
- R8: A chip select asserted by the transfer's control word stays low after the transfer ends.
- R9: The ready flag clears when index 0 is read with reg_rd high, and when a new transfer starts.
- R10: Control-word writes while busy are ignored: the counts, the chip select, the assert bit and the running transfer are all unchanged.
- R11: While index 4 bit 0 is 0, a started transfer makes no progress: busy stays 1 and sclk does not toggle. The transfer resumes when the bit is set. It resets to 0.
- R12: Setup words at indices 2, 3, 4, 5 and 6 read back the last value written.
- R13: A transmit count of 0 skips the transmit phase (sdo stays low). A receive count of 0 skips the receive phase and leaves the ready flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; at index 0 it clears the ready flag |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the target |
| sdi | input | 1 | Serial data from the target |
| cs_n | output | 4 | Active-low chip selects |

## Verification
A wrong bit counter or a wrong phase counter shows up as a busy window that is not exactly 4*(n+m) cycles long. It also shows up in the serial stream, as a wrong count of captured transmit bits or shifted receive data, and it does so within the transfer concerned. A wrong ready or chip-select state is visible on the control word or on cs_n in the cycle after the write or the transfer ends. The bench models a target that uses the opposite edge pair in inverted mode, so any edge mistake corrupts the data it exchanges.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int unsigned MW_DW  = 16;
  localparam int unsigned MW_CW  = 5;
  localparam int unsigned MW_NCS = 4;
  localparam int unsigned MW_DIV = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } mw_state_e;
endpackage

// File: rtl/mw_clkdiv.sv
module mw_clkdiv #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic busy_i,
  input  logic en_i,
  output logic tick_smp_o,
  output logic tick_end_o,
  output logic phase_hi_o
);
  localparam int unsigned PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int unsigned HALF = DIV / 2;

  logic [PW-1:0] ph_q, ph_d;
  logic          run;

  assign run = busy_i && en_i;

  always_comb begin
    ph_d = ph_q;
    if (restart_i) begin
      ph_d = '0;
    end else if (run) begin
      ph_d = (ph_q == PW'(DIV - 1)) ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign tick_smp_o = run && (ph_q == PW'(HALF - 1));
  assign tick_end_o = run && (ph_q == PW'(DIV - 1));
  assign phase_hi_o = busy_i && (ph_q >= PW'(HALF));

  // R11
  ph_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !restart_i) |=> $stable(ph_q));
endmodule

// File: rtl/mw_shift.sv
module mw_shift
  import mw_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] ld_tx_cnt_i,
  input  logic [CW-1:0] ld_rx_cnt_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tick_smp_i,
  input  logic          tick_end_i,
  input  logic          sdi_i,
  input  logic          rd_clear_i,
  output logic          busy_o,
  output logic          rdy_o,
  output logic [DW-1:0] rx_data_o,
  output logic          sdo_o
);
  mw_state_e     state_q, state_d;
  logic [CW-1:0] bits_q, bits_d;
  logic [CW-1:0] rxlen_q, rxlen_d;
  logic [DW-1:0] txsh_q, txsh_d;
  logic [DW-1:0] rxsh_q, rxsh_d;
  logic [DW-1:0] rxdat_q, rxdat_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    state_d = state_q;
    bits_d  = bits_q;
    rxlen_d = rxlen_q;
    txsh_d  = txsh_q;
    rxsh_d  = rxsh_q;
    rxdat_d = rxdat_q;
    rdy_d   = rdy_q;
    if (rd_clear_i) rdy_d = 1'b0;
    if (start_i) begin
      rdy_d   = 1'b0;
      txsh_d  = tx_data_i;
      rxsh_d  = '0;
      rxlen_d = ld_rx_cnt_i;
      if (ld_tx_cnt_i != '0) begin
        state_d = ST_TX;
        bits_d  = ld_tx_cnt_i;
      end else if (ld_rx_cnt_i != '0) begin
        state_d = ST_RX;
        bits_d  = ld_rx_cnt_i;
      end else begin
        state_d = ST_IDLE;
      end
    end else begin
      unique case (state_q)
        ST_TX: begin
          if (tick_end_i) begin
            txsh_d = {txsh_q[DW-2:0], 1'b0};
            if (bits_q == CW'(1)) begin
              if (rxlen_q != '0) begin
                state_d = ST_RX;
                bits_d  = rxlen_q;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              bits_d = bits_q - 1'b1;
            end
          end
        end
        ST_RX: begin
          if (tick_smp_i) rxsh_d = {rxsh_q[DW-2:0], sdi_i};
          if (tick_end_i) begin
            if (bits_q == CW'(1)) begin
              state_d = ST_IDLE;
              rdy_d   = 1'b1;
              rxdat_d = rxsh_q;
            end else begin
              bits_d = bits_q - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      rxlen_q <= '0;
      txsh_q  <= '0;
      rxsh_q  <= '0;
      rxdat_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      rxlen_q <= rxlen_d;
      txsh_q  <= txsh_d;
      rxsh_q  <= rxsh_d;
      rxdat_q <= rxdat_d;
      rdy_q   <= rdy_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign rdy_o     = rdy_q;
  assign rx_data_o = rxdat_q;
  assign sdo_o     = (state_q == ST_TX) && txsh_q[DW-1];

  // R5
  rdy_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> $fell(busy_o));

  // R13
  no_tx_sdo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ld_tx_cnt_i == '0) |=> !sdo_o);
endmodule

// File: rtl/mw_regs.sv
module mw_regs #(
  parameter int unsigned DW  = 16,
  parameter int unsigned CW  = 5,
  parameter int unsigned CSW = 2,
  parameter int unsigned AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic           busy_i,
  input  logic           rdy_i,
  input  logic [DW-1:0]  rx_data_i,
  output logic [DW-1:0]  tx_data_o,
  output logic [CSW-1:0] cs_idx_o,
  output logic           cs_cmd_o,
  output logic           start_o,
  output logic           rd_clear_o,
  output logic           clk_en_o,
  output logic           clk_inv_o
);
  localparam int unsigned NSETUP  = 5;
  localparam int unsigned SBASE   = 2;
  localparam int unsigned CMD_BIT = 2 * CW + CSW;
  localparam int unsigned GO_BIT  = CMD_BIT + 1;
  localparam int unsigned CSRW    = GO_BIT + 3;

  logic [DW-1:0]  tx_q, tx_d;
  logic [CW-1:0]  rxc_q, rxc_d, txc_q, txc_d;
  logic [CSW-1:0] csi_q, csi_d;
  logic           cmd_q, cmd_d;
  logic [DW-1:0]  setup_q [NSETUP];
  logic [DW-1:0]  setup_d [NSETUP];
  logic           csr_hit, csr_wr;
  logic [CSRW-1:0] csr_word;

  assign csr_hit = wr_i && (addr_i == AW'(1));
  assign csr_wr  = csr_hit && !busy_i;

  always_comb begin
    tx_d  = tx_q;
    rxc_d = rxc_q;
    txc_d = txc_q;
    csi_d = csi_q;
    cmd_d = cmd_q;
    for (int i = 0; i < NSETUP; i++) setup_d[i] = setup_q[i];
    if (wr_i && addr_i == '0) tx_d = wdata_i;
    if (csr_wr) begin
      rxc_d = wdata_i[CW-1:0];
      txc_d = wdata_i[2*CW-1:CW];
      csi_d = wdata_i[CMD_BIT-1:2*CW];
      cmd_d = wdata_i[CMD_BIT];
    end
    for (int i = 0; i < NSETUP; i++) begin
      if (wr_i && addr_i == AW'(i + SBASE)) setup_d[i] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rxc_q <= '0;
      txc_q <= '0;
      csi_q <= '0;
      cmd_q <= 1'b0;
      for (int i = 0; i < NSETUP; i++) setup_q[i] <= '0;
    end else begin
      tx_q  <= tx_d;
      rxc_q <= rxc_d;
      txc_q <= txc_d;
      csi_q <= csi_d;
      cmd_q <= cmd_d;
      for (int i = 0; i < NSETUP; i++) setup_q[i] <= setup_d[i];
    end
  end

  assign csr_word = {rdy_i, busy_i, 1'b0, cmd_q, csi_q, txc_q, rxc_q};

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o = rx_data_i;
    if (addr_i == AW'(1)) rdata_o = DW'(csr_word);
    for (int i = 0; i < NSETUP; i++) begin
      if (addr_i == AW'(i + SBASE)) rdata_o = setup_q[i];
    end
  end

  assign tx_data_o  = tx_q;
  assign cs_idx_o   = csi_q;
  assign cs_cmd_o   = cmd_q;
  assign start_o    = csr_wr && wdata_i[GO_BIT];
  assign rd_clear_o = rd_i && (addr_i == '0);
  assign clk_en_o   = setup_q[2][0];
  assign clk_inv_o  = setup_q[3][0];

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o && (wdata_i[2*CW-1:0] != '0) |=> busy_i);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_hit && busy_i) |=> ($stable(csi_q) && $stable(cmd_q) && $stable(txc_q) && busy_i));

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear_o && !busy_i) |=> !rdy_i);
endmodule

// File: rtl/mw_master.sv
module mw_master
  import mw_pkg::*;
#(
  parameter int unsigned DW  = MW_DW,
  parameter int unsigned CW  = MW_CW,
  parameter int unsigned NCS = MW_NCS,
  parameter int unsigned DIV = MW_DIV
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     reg_addr,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           sclk,
  output logic           sdo,
  input  logic           sdi,
  output logic [NCS-1:0] cs_n
);
  localparam int unsigned CSW = (NCS > 1) ? $clog2(NCS) : 1;

  logic           rst_m, rst_s;
  logic           busy, rdy, start, rd_clear, clk_en, clk_inv;
  logic           tick_smp, tick_end, phase_hi;
  logic [DW-1:0]  tx_data, rx_data;
  logic [CSW-1:0] cs_idx;
  logic           cs_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  mw_regs #(.DW(DW), .CW(CW), .CSW(CSW), .AW(3)) u_regs (
    .clk(clk), .rst_n(rst_s),
    .addr_i(reg_addr), .wr_i(reg_wr), .rd_i(reg_rd),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata),
    .busy_i(busy), .rdy_i(rdy), .rx_data_i(rx_data),
    .tx_data_o(tx_data), .cs_idx_o(cs_idx), .cs_cmd_o(cs_cmd),
    .start_o(start), .rd_clear_o(rd_clear),
    .clk_en_o(clk_en), .clk_inv_o(clk_inv)
  );

  mw_clkdiv #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_s),
    .restart_i(start), .busy_i(busy), .en_i(clk_en),
    .tick_smp_o(tick_smp), .tick_end_o(tick_end), .phase_hi_o(phase_hi)
  );

  mw_shift #(.DW(DW), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_s),
    .start_i(start),
    .ld_tx_cnt_i(reg_wdata[2*CW-1:CW]),
    .ld_rx_cnt_i(reg_wdata[CW-1:0]),
    .tx_data_i(tx_data),
    .tick_smp_i(tick_smp), .tick_end_i(tick_end),
    .sdi_i(sdi), .rd_clear_i(rd_clear),
    .busy_o(busy), .rdy_o(rdy), .rx_data_o(rx_data), .sdo_o(sdo)
  );

  assign sclk = clk_inv ^ phase_hi;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_n[g] = !(cs_cmd && (cs_idx == CSW'(g)));
  end

  // R2
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(~cs_n));

  // R7
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> (sclk == clk_inv));
endmodule

// File: tb/mw_master_tb_top.sv
`timescale 1ns/1ps
module mw_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sclk, sdo, sdi;
  logic [3:0]  cs_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // target model state
  bit          sl_act = 1'b0;
  bit          sl_inv = 1'b0;
  int          sl_txn = 0;
  int          sl_rxn = 0;
  logic [15:0] sl_pat = '0;
  logic [15:0] sl_cap = '0;
  int          sl_e = 0;

  always #5 clk = ~clk;

  mw_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_n(cs_n)
  );

  // capture edge: leaves the idle level
  always @(sclk) begin
    if (sl_act && (sclk != sl_inv)) begin
      if (sl_e < sl_txn) sl_cap = {sl_cap[14:0], sdo};
      sl_e = sl_e + 1;
    end
  end

  always_comb begin
    int k;
    k = sl_e - sl_txn;
    if (sl_act && k >= 0 && k < sl_rxn) sdi = sl_pat[sl_rxn - 1 - k];
    else sdi = 1'b0;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input bit pulse, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = pulse;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [15:0] ctl(int rxn, int txn, int cs, bit cmd, bit go);
    return 16'(rxn) | (16'(txn) << 5) | (16'(cs) << 10) | (16'(cmd) << 12) | (16'(go) << 13);
  endfunction

  task automatic wait_idle(output int cyc);
    reg_addr = 3'd1;
    #1;
    cyc = 0;
    while (reg_rdata[14]) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic xfer(input logic [15:0] txd, input int txn, input int rxn,
                      input logic [15:0] pat, input int cs,
                      output logic [15:0] cap, output int cyc);
    sl_txn = txn; sl_rxn = rxn; sl_pat = pat; sl_e = 0; sl_cap = '0; sl_act = 1'b1;
    wr_reg(3'd0, txd);
    wr_reg(3'd1, ctl(rxn, txn, cs, 1'b1, 1'b1));
    wait_idle(cyc);
    sl_act = 1'b0;
    cap = sl_cap;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd_reg(3'd1, 1'b0, d);
    check(d == 16'h0, "R1 control word", d, 0);
    check(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
    check(sclk == 1'b0 && sdo == 1'b0, "R1 sclk/sdo", {sclk, sdo}, 0);
  endtask

  task automatic t_setup();
    logic [15:0] d;
    wr_reg(3'd2, 16'h0ABC);
    wr_reg(3'd3, 16'h0123);
    wr_reg(3'd6, 16'hBEEF);
    wr_reg(3'd4, 16'h0001);
    rd_reg(3'd2, 1'b0, d); check(d == 16'h0ABC, "R12 setup2", d, 16'h0ABC);
    rd_reg(3'd3, 1'b0, d); check(d == 16'h0123, "R12 setup3", d, 16'h0123);
    rd_reg(3'd6, 1'b0, d); check(d == 16'hBEEF, "R12 setup6", d, 16'hBEEF);
    rd_reg(3'd4, 1'b0, d); check(d == 16'h0001, "R12 setup4", d, 1);
  endtask

  task automatic t_cs_cmd();
    logic [15:0] d;
    wr_reg(3'd1, ctl(0, 0, 2, 1'b1, 1'b0));
    check(cs_n == 4'b1011, "R2 cs_n", cs_n, 4'b1011);
    rd_reg(3'd1, 1'b0, d);
    check(d == 16'h1800, "R2 control readback", d, 16'h1800);
    wr_reg(3'd1, ctl(0, 0, 2, 1'b0, 1'b0));
    check(cs_n == 4'hF, "R3 cs_n released", cs_n, 4'hF);
  endtask

  task automatic t_basic();
    logic [15:0] cap, d;
    int cyc;
    xfer(16'hA500, 8, 8, 16'h003C, 0, cap, cyc);
    check(cap == 16'h00A5, "R4 sdo bits", cap, 16'h00A5);
    check(cyc == 64, "R6 busy cycles", cyc, 64);
    check(cs_n == 4'b1110, "R8 cs held", cs_n, 4'b1110);
    rd_reg(3'd1, 1'b0, d);
    check(d[15] == 1'b1, "R5 ready flag", d[15], 1);
    rd_reg(3'd0, 1'b0, d);
    check(d == 16'h003C, "R5 rx data", d, 16'h003C);
    // R9: new start clears ready; R13: rx count 0
    xfer(16'h9000, 4, 0, 16'h0, 0, cap, cyc);
    check(cap == 16'h0009, "R4 4-bit tx", cap, 9);
    check(cyc == 16, "R6 tx-only cycles", cyc, 16);
    rd_reg(3'd1, 1'b0, d);
    check(d[15] == 1'b0, "R9 start clears ready / R13 no rx", d[15], 0);
  endtask

  task automatic t_rx_only();
    logic [15:0] cap, d;
    int cyc;
    xfer(16'hFFFF, 0, 12, 16'h0ABC, 3, cap, cyc);
    check(cyc == 48, "R13 rx-only cycles", cyc, 48);
    check(cap == 16'h0, "R13 sdo low", cap, 0);
    rd_reg(3'd0, 1'b1, d);
    check(d == 16'h0ABC, "R5 12-bit rx", d, 16'h0ABC);
    rd_reg(3'd1, 1'b0, d);
    check(d[15] == 1'b0, "R9 read clears ready", d[15], 0);
  endtask

  task automatic t_inverted();
    logic [15:0] cap, d;
    int cyc;
    wr_reg(3'd5, 16'h0001);
    sl_inv = 1'b1;
    check(sclk == 1'b1, "R7 inverted idle", sclk, 1);
    xfer(16'h1234, 16, 16, 16'hFEDC, 1, cap, cyc);
    check(cap == 16'h1234, "R7 inverted tx", cap, 16'h1234);
    check(cyc == 128, "R6 32-bit cycles", cyc, 128);
    rd_reg(3'd0, 1'b1, d);
    check(d == 16'hFEDC, "R7 inverted rx", d, 16'hFEDC);
    wr_reg(3'd5, 16'h0000);
    sl_inv = 1'b0;
    check(sclk == 1'b0, "R7 normal idle", sclk, 0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] d;
    int cyc;
    sl_txn = 8; sl_rxn = 0; sl_pat = '0; sl_e = 0; sl_cap = '0; sl_act = 1'b1;
    wr_reg(3'd0, 16'hC300);
    wr_reg(3'd1, ctl(0, 8, 1, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    wr_reg(3'd1, ctl(4, 4, 3, 1'b1, 1'b1));
    wait_idle(cyc);
    sl_act = 1'b0;
    check(sl_cap == 16'h00C3, "R10 transfer intact", sl_cap, 16'hC3);
    rd_reg(3'd1, 1'b0, d);
    check(d == 16'h1500, "R10 fields unchanged", d, 16'h1500);
    check(cs_n == 4'b1101, "R10 cs unchanged", cs_n, 4'b1101);
  endtask

  task automatic t_clk_enable();
    logic [15:0] d;
    int cyc;
    wr_reg(3'd4, 16'h0000);
    sl_txn = 4; sl_rxn = 0; sl_e = 0; sl_cap = '0; sl_act = 1'b1;
    wr_reg(3'd0, 16'h5000);
    wr_reg(3'd1, ctl(0, 4, 0, 1'b1, 1'b1));
    repeat (20) @(negedge clk);
    rd_reg(3'd1, 1'b0, d);
    check(d[14] == 1'b1, "R11 stalled busy", d[14], 1);
    check(sl_e == 0 && sclk == 1'b0, "R11 no sclk edges", sl_e, 0);
    wr_reg(3'd4, 16'h0001);
    wait_idle(cyc);
    sl_act = 1'b0;
    check(sl_cap == 16'h0005, "R11 resumed data", sl_cap, 5);
    wr_reg(3'd1, ctl(0, 0, 0, 1'b0, 1'b0));
    check(cs_n == 4'hF, "R3 final release", cs_n, 4'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_setup();
    t_cs_cmd();
    t_basic();
    t_rx_only();
    t_inverted();
    t_busy_ignore();
    t_clk_enable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule